// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache for aligned 32-bit word accesses. It sits between a processor port and a main-memory port, and each port uses a valid/ready handshake. The cache holds two ways per set. Each way entry keeps a valid flag, a dirty flag, a tag and a line of several words. Each set keeps one bit that records which way was used last.

Stores use write-back with write-allocate. A store that hits changes only the cached line and marks that line dirty. A store that misses first brings the whole line in from memory and then merges the word into it. Main memory is written only when a dirty line is displaced. A clean line that is displaced is simply overwritten.

The cache serves one request at a time. On a miss the controller takes these steps in order: it copies a dirty victim out word by word, it reads the new line word by word, it replays the lookup (which now hits), and it returns the word.

Top module: `wb2_cache`

## Requirements
- R1: A byte address splits, from the least significant bit upward, into 2 byte bits that are ignored, log2(LINE_WORDS) word-select bits, log2(SETS) set bits and a tag made of the remaining upper bits. With the defaults (4-word lines, 2 sets), addresses 0x000 and 0x020 map to set 0 with different tags.
- R2: A read hit issues no memory request. Its response is valid on the second rising edge after the request is accepted.
- R3: On a miss, an invalid way of the set is filled before any valid way is displaced. Way 0 is chosen before way 1.
- R4: When both ways are valid, the victim is the way that was not used most recently. The last-used bit of a set is updated on every hit and on every refill.
- R5: A store hit updates only the cached word and marks the line dirty. It causes no memory write. A dirty flag is never set on an invalid entry.
- R6: A store miss reads the full line from memory (LINE_WORDS reads at ascending word addresses, starting at the line base). It then writes the word into the line, which is left dirty.
- R7: A dirty victim is written back as LINE_WORDS memory writes at ascending addresses from its line base, and all of them come before the first refill read. A clean victim causes no memory write. A memory request that is not accepted holds its address and its direction.
- R8: The processor request ready is high only in the idle state. It stays low from acceptance until the response handshake.
- R9: Reset invalidates every line and clears every dirty and last-used bit. After reset, request ready is high, response valid is low and memory request valid is low, and the first access to any line misses.
- R10: A read returns the most recently stored value for its address. A store returns the stored word. A response held back by the processor keeps its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address, word aligned |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_resp_valid | output | 1 | Response present |
| cpu_resp_ready | input | 1 | Processor takes the response |
| cpu_resp_rdata | output | DATA_W | Load data, or the stored word for a store |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_req_addr | output | ADDR_W | Word byte address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_resp_valid | input | 1 | Refill word returned |
| mem_resp_rdata | input | DATA_W | Refill word |

## Verification
The assertions assume two things about memory. It returns exactly one refill word for each accepted read, and never returns one at any other time. It needs no response for a write. The assertions also assume that processor addresses are word aligned. The stimulus meets these conditions with a memory model that answers each accepted read one cycle later. That model drops its ready on every third cycle, so that the hold rules on stalled requests are exercised. The processor side always issues aligned addresses inside a 256-byte window. This window spans 16 lines that compete for 4 entries, which forces frequent clean and dirty evictions.

// File: rtl/wb2_pkg.sv
package wb2_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TAG,
      ST_WB,
      ST_FREQ,
      ST_FWAIT,
      ST_RESP
   } wb2_state_t;
endpackage

// File: rtl/wb2_way.sv
module wb2_way #(
   parameter int SETS   = 2,
   parameter int WORDS  = 4,
   parameter int TAG_W  = 27,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(SETS),
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  set_i,
   input  logic [OFF_W-1:0]  rd_word_i,
   input  logic              wr_en_i,
   input  logic [OFF_W-1:0]  wr_word_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_dirty_i,
   input  logic              install_i,
   input  logic [TAG_W-1:0]  install_tag_i,
   output logic              valid_o,
   output logic              dirty_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] word_o
);
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS][WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (install_i) begin
         valid_q[set_i] <= 1'b1;
         dirty_q[set_i] <= 1'b0;
      end else if (wr_en_i && wr_dirty_i) begin
         dirty_q[set_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (install_i) tag_q[set_i] <= install_tag_i;
      if (wr_en_i)   data_q[set_i][wr_word_i] <= wr_data_i;
   end

   assign valid_o = valid_q[set_i];
   assign dirty_o = dirty_q[set_i];
   assign tag_o   = tag_q[set_i];
   assign word_o  = data_q[set_i][rd_word_i];

   // R5: a dirty entry is always a valid entry
   assert_dirty_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((dirty_q & ~valid_q) == '0));
endmodule

// File: rtl/wb2_lru.sv
module wb2_lru #(
   parameter int SETS = 2,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_i,
   input  logic             touch_i,
   input  logic             touch_way_i,
   output logic             mru_o
);
   logic [SETS-1:0] mru_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mru_q <= '0;
      else if (touch_i) mru_q[set_i] <= touch_way_i;
   end

   assign mru_o = mru_q[set_i];
endmodule

// File: rtl/wb2_cache.sv
module wb2_cache
   import wb2_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic              cpu_req_we,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_resp_valid,
   input  logic              cpu_resp_ready,
   output logic [DATA_W-1:0] cpu_resp_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_resp_valid,
   input  logic [DATA_W-1:0] mem_resp_rdata
);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int OFF_W  = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
   localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

   wb2_state_t        state_q;
   logic              req_we_q, victim_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic [DATA_W-1:0] req_wdata_q, resp_q;
   logic [OFF_W-1:0]  cnt_q;

   logic [IDX_W-1:0]  set_q;
   logic [OFF_W-1:0]  word_q, rd_word, wr_word;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] wr_data;
   logic [1:0]        w_valid, w_dirty, hit_vec, word_we, install_we;
   logic [TAG_W-1:0]  w_tag  [2];
   logic [DATA_W-1:0] w_word [2];
   logic              hit, hit_way, mru, victim_c;

   assign set_q  = req_addr_q[BYTE_W+OFF_W +: IDX_W];
   assign word_q = req_addr_q[BYTE_W +: OFF_W];
   assign tag_q  = req_addr_q[ADDR_W-1 -: TAG_W];

   assign rd_word = (state_q == ST_WB) ? cnt_q : word_q;
   assign wr_word = (state_q == ST_FWAIT) ? cnt_q : word_q;
   assign wr_data = (state_q == ST_FWAIT) ? mem_resp_rdata : req_wdata_q;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_way
         assign hit_vec[g] = w_valid[g] && (w_tag[g] == tag_q);
         wb2_way #(
            .SETS(SETS), .WORDS(LINE_WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
         ) u_way (
            .clk(clk), .rst_n(rst_n), .set_i(set_q), .rd_word_i(rd_word),
            .wr_en_i(word_we[g]), .wr_word_i(wr_word), .wr_data_i(wr_data),
            .wr_dirty_i(state_q == ST_TAG), .install_i(install_we[g]),
            .install_tag_i(tag_q), .valid_o(w_valid[g]), .dirty_o(w_dirty[g]),
            .tag_o(w_tag[g]), .word_o(w_word[g])
         );
      end
   endgenerate

   assign hit      = |hit_vec;
   assign hit_way  = hit_vec[1];
   assign victim_c = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : ~mru);

   wb2_lru #(.SETS(SETS)) u_lru (
      .clk(clk), .rst_n(rst_n), .set_i(set_q),
      .touch_i(state_q == ST_TAG && hit), .touch_way_i(hit_way), .mru_o(mru)
   );

   always_comb begin
      for (int i = 0; i < 2; i++) begin
         word_we[i] = (state_q == ST_TAG && hit && req_we_q && hit_way == 1'(i))
                   || (state_q == ST_FWAIT && mem_resp_valid && victim_q == 1'(i));
         install_we[i] = state_q == ST_FWAIT && mem_resp_valid
                      && cnt_q == LAST && victim_q == 1'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         victim_q    <= 1'b0;
         req_we_q    <= 1'b0;
         req_addr_q  <= '0;
         req_wdata_q <= '0;
         resp_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cpu_req_valid) begin
               req_we_q    <= cpu_req_we;
               req_addr_q  <= cpu_req_addr;
               req_wdata_q <= cpu_req_wdata;
               state_q     <= ST_TAG;
            end
            ST_TAG: begin
               cnt_q <= '0;
               if (hit) begin
                  resp_q  <= req_we_q ? req_wdata_q : w_word[hit_way];
                  state_q <= ST_RESP;
               end else begin
                  victim_q <= victim_c;
                  state_q  <= (w_valid[victim_c] && w_dirty[victim_c]) ? ST_WB : ST_FREQ;
               end
            end
            ST_WB: if (mem_req_ready) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) state_q <= ST_FREQ;
            end
            ST_FREQ: if (mem_req_ready) state_q <= ST_FWAIT;
            ST_FWAIT: if (mem_resp_valid) begin
               cnt_q   <= cnt_q + 1'b1;
               state_q <= (cnt_q == LAST) ? ST_TAG : ST_FREQ;
            end
            ST_RESP: if (cpu_resp_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_req_ready  = (state_q == ST_IDLE);
   assign cpu_resp_valid = (state_q == ST_RESP);
   assign cpu_resp_rdata = resp_q;
   assign mem_req_valid  = (state_q == ST_WB) || (state_q == ST_FREQ);
   assign mem_req_we     = (state_q == ST_WB);
   assign mem_req_addr   = (state_q == ST_WB)
                         ? {w_tag[victim_q], set_q, cnt_q, {BYTE_W{1'b0}}}
                         : {tag_q, set_q, cnt_q, {BYTE_W{1'b0}}};
   assign mem_req_wdata  = w_word[victim_q];

   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

   assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_resp_valid && !cpu_resp_ready) |=> (cpu_resp_valid && $stable(cpu_resp_rdata)));

   assert_memreq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
endmodule

// File: tb/sim_wb2_cache.sv
module sim_wb2_cache;
   localparam int CLK_PERIOD = 10;
   localparam int LW         = 4;
   localparam int NSETS      = 2;
   localparam int MEMW       = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0, cpu_resp_ready = 1'b1;
   logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
   logic        cpu_req_ready, cpu_resp_valid;
   logic [31:0] cpu_resp_rdata;
   logic        mem_req_valid, mem_req_we;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
   logic [31:0] mem_resp_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wb2_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
      .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
      .cpu_resp_ready(cpu_resp_ready), .cpu_resp_rdata(cpu_resp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
      .mem_resp_rdata(mem_resp_rdata)
   );

   int checks = 0, errors = 0;
   int hits = 0, misses = 0;

   // main-memory model, the only writer of its own state and logs
   logic [31:0] mem [MEMW];
   int          cyc = 0, rd_total = 0, wr_total = 0, rd_at_last_wr = 0;
   logic [31:0] rd_log [4096];
   logic [31:0] wr_log [4096];
   logic [31:0] wd_log [4096];

   always @(posedge clk) begin
      cyc++;
      mem_req_ready  <= (cyc % 3) != 2;
      mem_resp_valid <= 1'b0;
      if (!rst_n) begin
         for (int i = 0; i < MEMW; i++) mem[i] = 32'hA500_0000 + i;
      end else if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            wr_log[wr_total % 4096] = mem_req_addr;
            wd_log[wr_total % 4096] = mem_req_wdata;
            wr_total++;
            rd_at_last_wr = rd_total;
            mem[mem_req_addr[9:2]] = mem_req_wdata;
         end else begin
            rd_log[rd_total % 4096] = mem_req_addr;
            rd_total++;
            mem_resp_valid <= 1'b1;
            mem_resp_rdata <= mem[mem_req_addr[9:2]];
         end
      end
   end

   // R8 monitor: ready must stay low while a request is in flight
   logic in_flight = 1'b0;
   int   ready_viol = 0;
   always @(negedge clk) if (in_flight && cpu_req_ready) ready_viol++;

   // behavioural reference: flat memory plus a two-way last-used model
   logic [31:0] ref_mem [MEMW];
   int          m_line [NSETS][2];
   bit          m_v [NSETS][2];
   bit          m_d [NSETS][2];
   bit          m_mru [NSETS];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd);
      int line, s, hw, v, exp_rd, exp_wr, wb_base, fill_base, rd0, wr0, viol0, lat;
      logic [31:0] exp_data;
      line = int'(addr >> 4);
      s = line % NSETS;
      hw = -1;
      exp_rd = 0; exp_wr = 0; wb_base = 0; fill_base = line * 16;
      for (int w = 0; w < 2; w++) if (m_v[s][w] && m_line[s][w] == line) hw = w;
      if (hw >= 0) begin
         hits++;
         m_mru[s] = hw[0];
         if (we) m_d[s][hw] = 1'b1;
      end else begin
         misses++;
         v = !m_v[s][0] ? 0 : (!m_v[s][1] ? 1 : (m_mru[s] ? 0 : 1));
         if (m_v[s][v] && m_d[s][v]) begin
            exp_wr = LW;
            wb_base = m_line[s][v] * 16;
         end
         exp_rd = LW;
         m_v[s][v] = 1'b1; m_line[s][v] = line; m_d[s][v] = we; m_mru[s] = v[0];
      end
      exp_data = we ? wd : ref_mem[addr[9:2]];
      rd0 = rd_total; wr0 = wr_total; viol0 = ready_viol;

      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = addr; cpu_req_wdata = wd;
      while (!cpu_req_ready) @(negedge clk);
      @(posedge clk);
      in_flight = 1'b1;
      @(negedge clk);
      cpu_req_valid = 1'b0;
      lat = 1;
      while (!cpu_resp_valid) begin
         @(negedge clk);
         lat++;
      end
      check(cpu_resp_rdata == exp_data, "R10 response data", cpu_resp_rdata, exp_data);
      @(posedge clk);
      in_flight = 1'b0;

      if (hw >= 0) check(lat == 2, "R2 hit latency", lat, 2);
      check(rd_total - rd0 == exp_rd, we ? "R6 refill read count" : "R1 refill read count",
            rd_total - rd0, exp_rd);
      check(wr_total - wr0 == exp_wr, "R7 write-back count", wr_total - wr0, exp_wr);
      for (int k = 0; k < exp_rd && k < rd_total - rd0; k++)
         check(rd_log[(rd0 + k) % 4096] == 32'(fill_base + 4*k), "R6 refill address",
               rd_log[(rd0 + k) % 4096], 32'(fill_base + 4*k));
      for (int k = 0; k < exp_wr && k < wr_total - wr0; k++) begin
         check(wr_log[(wr0 + k) % 4096] == 32'(wb_base + 4*k), "R7 write-back address",
               wr_log[(wr0 + k) % 4096], 32'(wb_base + 4*k));
         check(wd_log[(wr0 + k) % 4096] == ref_mem[(wb_base/4 + k) % MEMW],
               "R5 write-back data", wd_log[(wr0 + k) % 4096],
               ref_mem[(wb_base/4 + k) % MEMW]);
      end
      if (exp_wr > 0)
         check(rd_at_last_wr == rd0, "R7 write-back before refill", rd_at_last_wr, rd0);
      check(ready_viol == viol0, "R8 ready low while busy", ready_viol - viol0, 0);
      if (we) ref_mem[addr[9:2]] = wd;
   endtask

   // watchdog: counts as a failed check and still prints the summary
   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int w0;
      for (int i = 0; i < MEMW; i++) ref_mem[i] = 32'hA500_0000 + i;
      for (int s = 0; s < NSETS; s++) begin
         m_mru[s] = 1'b0;
         for (int w = 0; w < 2; w++) begin
            m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; m_line[s][w] = 0;
         end
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state at the ports
      check(cpu_req_ready == 1'b1, "R9 ready after reset", cpu_req_ready, 1);
      check(cpu_resp_valid == 1'b0, "R9 no response after reset", cpu_resp_valid, 0);
      check(mem_req_valid == 1'b0, "R9 no memory request after reset", mem_req_valid, 0);

      // R1/R3/R4: two lines that share set 0 coexist in two ways
      access(1'b0, 32'h000, '0);
      check(misses == 1, "R9 first access misses", misses, 1);
      access(1'b0, 32'h020, '0);
      check(misses == 2, "R3 second line fills free way", misses, 2);
      access(1'b0, 32'h000, '0);
      access(1'b0, 32'h020, '0);
      check(hits == 2, "R1 repeat pair hits", hits, 2);
      // R2: another word of a resident line
      access(1'b0, 32'h004, '0);
      // R5: store hit, then read back
      access(1'b1, 32'h008, 32'hDEAD_BEEF);
      access(1'b0, 32'h008, '0);
      // R4/R7: clean victim (0x020 line) displaced by 0x040, no write-back
      w0 = wr_total;
      access(1'b0, 32'h040, '0);
      check(wr_total == w0, "R7 clean victim not written", wr_total - w0, 0);
      access(1'b0, 32'h000, '0);
      check(hits == 6, "R4 recently used line kept", hits, 6);
      // R7: dirty 0x000 line is now the victim of 0x060 after touching 0x040
      access(1'b0, 32'h040, '0);
      w0 = wr_total;
      access(1'b0, 32'h060, '0);
      check(wr_total - w0 == LW, "R7 dirty victim written back", wr_total - w0, LW);
      access(1'b0, 32'h008, '0);
      // R6: store miss allocates the line
      access(1'b1, 32'h094, 32'h1234_5678);
      access(1'b0, 32'h094, '0);
      access(1'b0, 32'h090, '0);

      // mixed traffic across 16 lines competing for 4 entries
      r = 32'h1357_9BDF;
      for (int n = 0; n < 400; n++) begin
         r ^= r << 13; r ^= r >> 17; r ^= r << 5;
         access(r[31:30] < 2'd1 || r[29], {24'h0, r[7:2], 2'b00}, r ^ 32'h5A5A_0000);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule